// File: doc/BRIEF.md
# HDLC Receive Byte Buffer with Frame Status

This block takes the byte stream from an HDLC deframer and holds it for a host until the host reads it. It stores data bytes in a 128-entry buffer. At the close of every frame it adds one status entry, so the host can see frame boundaries and frame quality in the same stream it reads data from. Each entry has a ninth bit that marks it as data or status.

The host reads one entry per strobe and sees how many entries are waiting. Three sticky interrupt flags report frame end, a fill level above a programmable threshold, and overrun. Each flag has its own mask bit and is cleared by writing 1 to it.

The block has a channel reset, a channel enable and a frame alignment input. Reset empties the buffer and clears the flags. Disable and loss of alignment only stop intake and drop the frame in progress.

Top module: `hdlc_rx_fifo`

## Requirements
- R1: A data byte offered with `rx_valid_i` while the channel is active is stored as entry `{1'b0, byte}`. `rd_data_o` shows the oldest entry, and a `rd_i` pulse removes it, so bytes come out in arrival order.
- R2: An `rx_eof_i` pulse on an active channel stores one status entry with bit 8 = 1. In its low byte, bit0 = good (no error and no overrun), bit1 = CRC error, bit2 = abort and bit3 = overrun in this frame; bits 7:4 are 0. A data byte offered in the same cycle as `rx_eof_i` is not stored.
- R3: `avail_o` equals the number of stored entries, never exceeds 128, and does not change when `rd_i` is given while it is 0.
- R4: A data byte that arrives while 128 entries are stored is dropped and sets the overrun flag. Every later data byte of that frame is also dropped, even after the host frees space. The frame's status then has bit3 set.
- R5: If a frame ends while 128 entries are stored, its status entry replaces the newest stored entry and `avail_o` stays at 128.
- R6: `irq_sts_o` holds sticky flags: bit0 = frame end, bit1 = `avail_o` above `thresh_i` (evaluated on the registered count), bit2 = overrun. A 1 in `irq_clr_i` clears a flag. A set condition in the same cycle as the clear wins.
- R7: `irq_o` is high exactly when some bit of `irq_sts_o & irq_mask_i` is 1.
- R8: A `chan_rst_i` pulse empties the buffer, clears all flags and abandons the frame in progress. The channel then ignores input until `chan_en_i` has been seen low.
- R9: While `chan_en_i` is low, input is ignored and the frame state is reset, so a pending overrun does not carry into the next frame. Stored entries and flags are kept.
- R10: While `frame_lock_i` is low, the channel behaves exactly as if it were disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chan_rst_i | input | 1 | Synchronous channel reset pulse |
| chan_en_i | input | 1 | Channel enable |
| frame_lock_i | input | 1 | Framer alignment good |
| rx_valid_i | input | 1 | Data byte valid |
| rx_data_i | input | 8 | Data byte |
| rx_eof_i | input | 1 | Frame end pulse |
| rx_crc_err_i | input | 1 | CRC error, qualifies `rx_eof_i` |
| rx_abort_i | input | 1 | Abort, qualifies `rx_eof_i` |
| rd_i | input | 1 | Host read strobe |
| rd_data_o | output | 9 | Oldest entry: tag bit and byte |
| avail_o | output | 10 | Stored entry count |
| thresh_i | input | 10 | Fill threshold |
| irq_mask_i | input | 3 | Interrupt enables |
| irq_clr_i | input | 3 | Write-1-to-clear strobes |
| irq_sts_o | output | 3 | Sticky interrupt flags |
| irq_o | output | 1 | Masked interrupt request |

## Verification
Two events can fall in the same cycle: the host clearing an interrupt flag, and that flag's set condition being true again. The bench provokes this by sweeping `thresh_i` from 0 to 6 with four entries stored and pulsing the clear in each step. The flag must read 1 after the edge exactly when 4 > threshold. A second collision is a data byte presented together with the frame end. It is judged by the entry count and by the next entry read.

// File: rtl/hrf_pkg.sv
package hrf_pkg;
  localparam int IRQ_N   = 3;
  localparam int IRQ_EOP = 0;
  localparam int IRQ_THR = 1;
  localparam int IRQ_OVR = 2;
  localparam int ENT_W   = 9;

  function automatic logic [ENT_W-1:0] mk_status(input logic crc, input logic abort,
                                                 input logic ovr);
    return {1'b1, 4'b0000, ovr, abort, crc, ~(crc | abort | ovr)};
  endfunction
endpackage

// File: rtl/hrf_store.sv
module hrf_store #(
  parameter int DEPTH = 128,
  parameter int CNT_W = 10,
  parameter int W     = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic             patch_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             pop_i,
  output logic [W-1:0]     rdata_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q, last_ptr;
  logic [CNT_W-1:0] count_q;
  logic             pop;

  assign last_ptr = wr_ptr_q - AW'(1);
  assign empty_o  = (count_q == '0);
  assign full_o   = (count_q == CNT_W'(DEPTH));
  assign pop      = pop_i & ~empty_o;
  assign rdata_o  = mem[rd_ptr_q];
  assign count_o  = count_q;

  always_ff @(posedge clk_i) begin
    if (push_i)       mem[wr_ptr_q] <= wdata_i;
    else if (patch_i) mem[last_ptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (pop)    rd_ptr_q <= rd_ptr_q + AW'(1);
      count_q <= count_q + CNT_W'(push_i) - CNT_W'(pop);
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  a_r3_empty_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i && !clr_i) |=> (count_q == '0));
  a_r5_patch_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (patch_i && !pop_i && !clr_i) |=> $stable(count_q));
endmodule

// File: rtl/hrf_wr_ctrl.sv
module hrf_wr_ctrl
  import hrf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_eof_i,
  input  logic             rx_crc_err_i,
  input  logic             rx_abort_i,
  input  logic             full_i,
  output logic             push_o,
  output logic             patch_o,
  output logic [ENT_W-1:0] wdata_o,
  output logic             eop_o,
  output logic             ovr_o
);
  logic dropping_q;

  always_comb begin
    push_o  = 1'b0;
    patch_o = 1'b0;
    wdata_o = '0;
    eop_o   = 1'b0;
    ovr_o   = 1'b0;
    if (!flush_i) begin
      if (rx_eof_i) begin
        wdata_o = mk_status(rx_crc_err_i, rx_abort_i, dropping_q);
        push_o  = ~full_i;
        patch_o = full_i;   // no room: status overwrites newest entry
        eop_o   = 1'b1;
      end else if (rx_valid_i) begin
        if (full_i || dropping_q) ovr_o = 1'b1;
        else begin
          push_o  = 1'b1;
          wdata_o = {1'b0, rx_data_i};
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      dropping_q <= 1'b0;
    else if (flush_i || rx_eof_i)     dropping_q <= 1'b0;
    else if (rx_valid_i && full_i)    dropping_q <= 1'b1;
  end

  a_r4_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> !full_i);
  a_r5_patch_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    patch_o |-> (full_i && rx_eof_i));
  a_r4_drop_persists: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !flush_i) ##1 (rx_valid_i && !rx_eof_i && !flush_i) |-> !push_o);
endmodule

// File: rtl/hrf_irq.sv
module hrf_irq
  import hrf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [IRQ_N-1:0] set_i,
  input  logic [IRQ_N-1:0] clr_i,
  input  logic [IRQ_N-1:0] mask_i,
  output logic [IRQ_N-1:0] sts_o,
  output logic             irq_o
);
  for (genvar i = 0; i < IRQ_N; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      flag_q <= 1'b0;
      else if (flush_i) flag_q <= 1'b0;
      else              flag_q <= set_i[i] | (flag_q & ~clr_i[i]);
    end
    assign sts_o[i] = flag_q;

    a_r6_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !flag_q);
    a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q && !clr_i[i] && !flush_i) |=> flag_q);
  end

  assign irq_o = |(sts_o & mask_i);
endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
  import hrf_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chan_rst_i,
  input  logic             chan_en_i,
  input  logic             frame_lock_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_eof_i,
  input  logic             rx_crc_err_i,
  input  logic             rx_abort_i,
  input  logic             rd_i,
  output logic [8:0]       rd_data_o,
  output logic [CNT_W-1:0] avail_o,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic [2:0]       irq_mask_i,
  input  logic [2:0]       irq_clr_i,
  output logic [2:0]       irq_sts_o,
  output logic             irq_o
);
  logic             armed_q, active;
  logic             push, patch, full, empty, eop_evt, ovr_evt;
  logic [ENT_W-1:0] wdata;
  logic [IRQ_N-1:0] irq_set;

  // after a channel reset, intake waits for the enable to be seen low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         armed_q <= 1'b1;
    else if (chan_rst_i) armed_q <= 1'b0;
    else if (!chan_en_i) armed_q <= 1'b1;
  end

  assign active = chan_en_i & frame_lock_i & armed_q & ~chan_rst_i;

  hrf_wr_ctrl u_wr (
    .clk_i, .rst_ni,
    .flush_i     (~active),
    .rx_valid_i, .rx_data_i, .rx_eof_i, .rx_crc_err_i, .rx_abort_i,
    .full_i      (full),
    .push_o      (push),
    .patch_o     (patch),
    .wdata_o     (wdata),
    .eop_o       (eop_evt),
    .ovr_o       (ovr_evt)
  );

  hrf_store #(.DEPTH(DEPTH), .CNT_W(CNT_W), .W(ENT_W)) u_store (
    .clk_i, .rst_ni,
    .clr_i   (chan_rst_i),
    .push_i  (push),
    .patch_i (patch),
    .wdata_i (wdata),
    .pop_i   (rd_i),
    .rdata_o (rd_data_o),
    .count_o (avail_o),
    .full_o  (full),
    .empty_o (empty)
  );

  always_comb begin
    irq_set          = '0;
    irq_set[IRQ_EOP] = eop_evt;
    irq_set[IRQ_THR] = (avail_o > thresh_i);
    irq_set[IRQ_OVR] = ovr_evt;
  end

  hrf_irq u_irq (
    .clk_i, .rst_ni,
    .flush_i (chan_rst_i),
    .set_i   (irq_set),
    .clr_i   (irq_clr_i),
    .mask_i  (irq_mask_i),
    .sts_o   (irq_sts_o),
    .irq_o
  );

  a_r8_rst_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_rst_i |=> (avail_o == '0 && irq_sts_o == '0));
  a_r9_idle_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && !rd_i && !chan_rst_i) |=> $stable(avail_o));
  a_r7_irq_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(irq_sts_o & irq_mask_i));
  a_r3_read_empty_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty && !push) |=> (avail_o == '0 || $past(active)));
endmodule

// File: tb/tb_hdlc_rx_fifo.sv
module tb_hdlc_rx_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 128;

  logic clk_i = 0, rst_ni = 0;
  logic chan_rst = 0, chan_en = 1, lock = 1;
  logic rx_valid = 0, rx_eof = 0, rx_crc = 0, rx_abort = 0, rd = 0;
  logic [7:0] rx_data = 0;
  logic [8:0] rd_data;
  logic [9:0] avail, thresh = 10'd1000;
  logic [2:0] irq_mask = 0, irq_clr = 0, irq_sts;
  logic irq;
  int n_chk = 0, n_fail = 0;
  logic [8:0] got;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  hdlc_rx_fifo dut (
    .clk_i, .rst_ni, .chan_rst_i(chan_rst), .chan_en_i(chan_en), .frame_lock_i(lock),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_eof_i(rx_eof),
    .rx_crc_err_i(rx_crc), .rx_abort_i(rx_abort), .rd_i(rd), .rd_data_o(rd_data),
    .avail_o(avail), .thresh_i(thresh), .irq_mask_i(irq_mask), .irq_clr_i(irq_clr),
    .irq_sts_o(irq_sts), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk_i); #1; endtask
  task automatic push_b(input logic [7:0] d);
    rx_valid = 1; rx_data = d; tick; rx_valid = 0;
  endtask
  task automatic end_frm(input logic c, input logic a, input logic v);
    rx_eof = 1; rx_crc = c; rx_abort = a; rx_valid = v; rx_data = 8'hEE;
    tick; rx_eof = 0; rx_crc = 0; rx_abort = 0; rx_valid = 0;
  endtask
  task automatic pop(output logic [8:0] d);
    d = rd_data; rd = 1; tick; rd = 0;
  endtask
  task automatic w1c(input logic [2:0] m);
    irq_clr = m; tick; irq_clr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick;
    rst_ni = 1; tick;
    check("R3 reset avail", avail, 0);
    check("R6 reset flags", irq_sts, 0);
    check("R7 reset irq", irq, 0);

    // R1/R2 basic frame
    for (int i = 0; i < 5; i++) push_b(8'h10 + 8'(i));
    end_frm(0, 0, 0);
    check("R3 count after frame", avail, 6);
    check("R6 eop flag", irq_sts[0], 1);
    for (int i = 0; i < 5; i++) begin pop(got); check("R1 data order", got, {1'b0, 8'h10 + 8'(i)}); end
    pop(got); check("R2 good status", got, 9'h101);
    rd = 1; tick; rd = 0;
    check("R3 read empty", avail, 0);

    // R2 status sweep
    for (int c = 0; c < 4; c++) begin
      push_b(8'h40 + 8'(c)); push_b(8'h41 + 8'(c));
      end_frm(c[0], c[1], 0);
      pop(got); check("R1 data a", got, {1'b0, 8'h40 + 8'(c)});
      pop(got); check("R1 data b", got, {1'b0, 8'h41 + 8'(c)});
      pop(got); check("R2 status bits", got, {1'b1, 5'b0, c[1], c[0], ~(c[0] | c[1])});
    end

    // R2 data byte with frame end is not stored
    push_b(8'h77);
    end_frm(0, 0, 1);
    check("R2 eof data dropped", avail, 2);
    pop(got); check("R2 data before eof", got, 9'h077);
    pop(got); check("R2 status after eof", got, 9'h101);

    // R6 threshold sweep, set wins over clear
    w1c(3'b111);
    check("R6 w1c all", irq_sts, 0);
    for (int i = 0; i < 4; i++) push_b(8'(i));
    for (int t = 0; t < 7; t++) begin
      thresh = 10'(t); tick;
      w1c(3'b010);
      check("R6 thr vs clear", irq_sts[1], 32'(4 > t));
    end
    thresh = 10'd1000; tick; w1c(3'b010);
    check("R6 thr cleared", irq_sts[1], 0);
    end_frm(0, 0, 0);
    thresh = 0; tick; tick;
    check("R6 flags eop thr", irq_sts, 3'b011);
    for (int m = 0; m < 8; m++) begin
      irq_mask = 3'(m); #1;
      check("R7 mask sweep", irq, 32'(|(3'(m) & 3'b011)));
    end
    irq_mask = 0; thresh = 10'd1000;
    for (int i = 0; i < 5; i++) pop(got);
    tick; w1c(3'b111);

    // R4 overrun
    for (int i = 0; i < DEPTH; i++) push_b(8'(i));
    check("R3 full count", avail, DEPTH);
    push_b(8'hFF);
    check("R4 ovr flag", irq_sts[2], 1);
    check("R4 count held", avail, DEPTH);
    pop(got); check("R1 first of full", got, 9'h000);
    push_b(8'hFE);
    check("R4 drop after space", avail, DEPTH - 1);
    end_frm(0, 0, 0);
    check("R4 status pushed", avail, DEPTH);
    for (int k = 0; k < DEPTH - 1; k++) begin
      pop(got);
      if (got !== {1'b0, 8'(k + 1)}) check("R4 drain data", got, {1'b0, 8'(k + 1)});
    end
    pop(got); check("R4 ovr status", got, 9'h108);

    // R5 status replaces newest when full, R9 disable resets frame state
    for (int i = 0; i < DEPTH; i++) push_b(8'(i) ^ 8'hA5);
    end_frm(0, 0, 0);
    check("R5 count stays", avail, DEPTH);
    push_b(8'h11);
    chan_en = 0; w1c(3'b111);
    push_b(8'h22); end_frm(0, 0, 0);
    check("R9 disabled count", avail, DEPTH);
    check("R9 disabled no flags", irq_sts, 0);
    chan_en = 1;
    pop(got); check("R9 contents kept", got, {1'b0, 8'h00 ^ 8'hA5});
    pop(got); check("R9 contents kept 2", got, {1'b0, 8'h01 ^ 8'hA5});
    end_frm(0, 0, 0);
    check("R9 count after new frame", avail, DEPTH - 1);
    for (int k = 2; k < DEPTH - 1; k++) pop(got);
    pop(got); check("R5 replaced status", got, 9'h101);
    pop(got); check("R9 ovr not carried", got, 9'h101);
    check("R3 drained", avail, 0);

    // R10 loss of alignment
    lock = 0; push_b(8'h33); end_frm(0, 0, 0);
    check("R10 unlocked ignored", avail, 0);
    lock = 1; push_b(8'h34);
    check("R10 relocked", avail, 1);

    // R8 channel reset
    tick; check("R8 flags before", irq_sts[1], 0);
    thresh = 0; tick; tick;
    chan_rst = 1; tick; chan_rst = 0;
    check("R8 count cleared", avail, 0);
    check("R8 flags cleared", irq_sts, 0);
    thresh = 10'd1000;
    push_b(8'h55);
    check("R8 stays disabled", avail, 0);
    chan_en = 0; tick; chan_en = 1;
    push_b(8'h56);
    check("R8 rearmed", avail, 1);
    pop(got); check("R8 rearmed data", got, 9'h056);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule